// File: doc/BRIEF.md
# AHB block security filter

This block sits between an AHB master port and a protected memory and decides, per address phase, whether a transfer may reach the memory. The memory is divided into equal blocks whose size is a power of two chosen by a size code. A bitmap input holds one security bit per block. The filter finds the block that the transfer address falls in and compares that bit with the transfer's non-secure attribute. A matching transfer is forwarded to the memory unchanged, and the memory's wait states, response and read data go back to the master.

A mismatching transfer is a violation and is never forwarded. A mode input selects how it is answered. It either completes at once with zero read data and its write dropped, or it receives a two-cycle error response. Each violation also produces a one-cycle report to a capture unit. A gating handshake lets a controller quiesce the memory port. While gating is requested, no new transfer is accepted. The acknowledge comes only once nothing is outstanding at the memory.

Top module: `ahb_blk_sec_filter`

## Requirements
- R1: The block number is the transfer address shifted right by (size_code + 5), so a block holds 2^(size_code+5) bytes. A block number at or above NUM_BLOCKS (64 by default) is treated as secure (bit 0).
- R2: blk_table bit n is 1 when block n is non-secure and 0 when it is secure. An active transfer whose s_hnonsec differs from its block's bit is a violation. A matching transfer is forwarded unchanged, and the memory's wait states, response and read data are returned to the master.
- R3: A violating transfer never reaches the memory: m_htrans stays IDLE (2'b00) in its address phase.
- R4: With err_mode = 0, a violation completes in its first data-phase cycle with s_hreadyout = 1, s_hresp = 0 (OKAY) and s_hrdata = 0. A violating write leaves the memory contents unchanged.
- R5: With err_mode = 1, a violation gets a two-cycle error: first s_hreadyout = 0 with s_hresp = 1 (ERROR), then s_hreadyout = 1 with s_hresp = 1.
- R6: Transfers of type IDLE (2'b00) or BUSY (2'b01) are never checked, raise no violation, and complete with OKAY and zero wait states. Only NONSEQ (2'b10) and SEQ (2'b11) are active. After reset s_hreadyout = 1 and s_hresp = 0.
- R7: Each violation raises viol_valid for exactly one cycle: the cycle after its address phase is accepted. Alongside it come the address, the non-secure attribute, the master ID and the looked-up table bit of that transfer.
- R8: While gate_req is high, no new address phase is accepted: s_hreadyout is low in place of acceptance, and m_htrans stays IDLE.
- R9: gate_ack is high only while gate_req is high and no transfer is outstanding at the memory. If an in-flight transfer completes at the memory while gating is requested, its response is held, and it is given to the master after gate_req falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| size_code | input | SIZE_W | Block size code; block bytes = 2^(size_code+5) |
| blk_table | input | NUM_BLOCKS | Per-block security bits, 1 = non-secure |
| err_mode | input | 1 | Violation reaction: 0 silent, 1 error response |
| gate_req | input | 1 | Request to quiesce the memory port |
| gate_ack | output | 1 | Memory port quiet while gating requested |
| s_haddr | input | ADDR_W | Master address |
| s_htrans | input | 2 | Master transfer type |
| s_hwrite | input | 1 | Master write flag |
| s_hsize | input | 3 | Master transfer size |
| s_hnonsec | input | 1 | Master non-secure attribute |
| s_hmaster | input | MASTER_W | Master ID |
| s_hwdata | input | DATA_W | Master write data |
| s_hrdata | output | DATA_W | Read data to master |
| s_hreadyout | output | 1 | Ready to master |
| s_hresp | output | 1 | Response to master, 1 = ERROR |
| m_haddr | output | ADDR_W | Memory address |
| m_htrans | output | 2 | Memory transfer type |
| m_hwrite | output | 1 | Memory write flag |
| m_hsize | output | 3 | Memory transfer size |
| m_hnonsec | output | 1 | Memory non-secure attribute |
| m_hwdata | output | DATA_W | Memory write data |
| m_hready | output | 1 | Bus ready seen by the memory |
| m_hrdata | input | DATA_W | Memory read data |
| m_hreadyout | input | 1 | Memory ready |
| m_hresp | input | 1 | Memory response |
| viol_valid | output | 1 | One-cycle violation report |
| viol_addr | output | ADDR_W | Violating address |
| viol_nonsec | output | 1 | Violating non-secure attribute |
| viol_master | output | MASTER_W | Violating master ID |
| viol_cfg | output | 1 | Table bit looked up for the violation |

## Verification
The gating request and the end of a forwarded transfer can fall in one cycle. The risky case is a request that arrives just as the memory completes a wait-stated read. To provoke it, the bench gives the memory two wait states and raises gate_req in the cycle where the memory returns ready. It then expects the acknowledge one cycle later, the master's ready held low for the whole gated window, and the memory's read data delivered intact to the master once the request is released. The stall with nothing in flight, and the error and silent reactions, are judged against the same scoreboard of expected responses.

// File: rtl/ahb_sf_pkg.sv
package ahb_sf_pkg;

  localparam logic [1:0] HTRANS_IDLE = 2'b00;

  // data-phase owner of the master's response
  typedef enum logic [2:0] {
    DP_NONE = 3'd0,   // no transfer in data phase
    DP_PASS = 3'd1,   // forwarded transfer, memory answers
    DP_RAZ  = 3'd2,   // silent blocked transfer
    DP_ERR1 = 3'd3,   // first error cycle
    DP_ERR2 = 3'd4,   // second error cycle
    DP_HOLD = 3'd5    // finished response parked while gated
  } dp_state_t;

endpackage

// File: rtl/sf_lookup.sv
module sf_lookup #(
  parameter int ADDR_W     = 32,
  parameter int NUM_BLOCKS = 64,
  parameter int SIZE_W     = 4
) (
  input  logic [ADDR_W-1:0]     addr,
  input  logic [SIZE_W-1:0]     size_code,
  input  logic [NUM_BLOCKS-1:0] blk_table,
  output logic                  cfg_ns
);

  localparam int IDX_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1;
  localparam int SH_W  = 6;

  logic [SH_W-1:0]   shamt;
  logic [ADDR_W-1:0] blk_num;
  logic              in_range;

  always_comb begin
    shamt    = SH_W'(size_code) + SH_W'(5);
    blk_num  = addr >> shamt;
    in_range = (blk_num < ADDR_W'(NUM_BLOCKS));
    // blocks past the table end are secure
    cfg_ns   = in_range ? blk_table[blk_num[IDX_W-1:0]] : 1'b0;
  end

endmodule

// File: rtl/sf_dphase.sv
module sf_dphase
  import ahb_sf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate_req,
  input  logic              err_mode,
  input  logic              xfer_active,
  input  logic              violation,
  input  logic [DATA_W-1:0] m_hrdata,
  input  logic              m_hreadyout,
  input  logic              m_hresp,
  output logic [DATA_W-1:0] s_hrdata,
  output logic              s_hreadyout,
  output logic              s_hresp,
  output logic              m_hready,
  output logic              accept,
  output logic              gate_ack
);

  dp_state_t         state_q, state_d;
  logic [DATA_W-1:0] hold_rdata_q;
  logic              hold_resp_q;
  logic              hold_en;

  always_comb begin
    s_hreadyout = 1'b1;
    s_hresp     = 1'b0;
    s_hrdata    = '0;
    m_hready    = 1'b1;
    state_d     = state_q;
    case (state_q)
      DP_NONE: s_hreadyout = !gate_req;
      DP_PASS: begin
        s_hreadyout = m_hreadyout && !gate_req;
        s_hresp     = m_hresp;
        s_hrdata    = m_hrdata;
        m_hready    = m_hreadyout;
      end
      DP_RAZ:  s_hreadyout = !gate_req;
      DP_ERR1: begin
        s_hreadyout = 1'b0;
        s_hresp     = 1'b1;
      end
      DP_ERR2: begin
        s_hreadyout = !gate_req;
        s_hresp     = 1'b1;
      end
      DP_HOLD: begin
        s_hreadyout = !gate_req;
        s_hresp     = hold_resp_q;
        s_hrdata    = hold_rdata_q;
      end
      default: ;
    endcase

    if (s_hreadyout) begin
      if (!xfer_active)    state_d = DP_NONE;
      else if (!violation) state_d = DP_PASS;
      else if (err_mode)   state_d = DP_ERR1;
      else                 state_d = DP_RAZ;
    end else begin
      case (state_q)
        DP_PASS:          if (m_hreadyout) state_d = DP_HOLD;
        DP_RAZ, DP_ERR2:  state_d = DP_HOLD;
        DP_ERR1:          state_d = DP_ERR2;
        default: ;
      endcase
    end
  end

  assign accept   = s_hreadyout;
  assign hold_en  = (state_q != DP_HOLD) && (state_d == DP_HOLD);
  assign gate_ack = gate_req && ((state_q == DP_NONE) || (state_q == DP_HOLD));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= DP_NONE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_rdata_q <= '0;
      hold_resp_q  <= 1'b0;
    end else if (hold_en) begin
      hold_rdata_q <= s_hrdata;
      hold_resp_q  <= s_hresp;
    end
  end

endmodule

// File: rtl/sf_viol_report.sv
module sf_viol_report #(
  parameter int ADDR_W   = 32,
  parameter int MASTER_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hit,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                nonsec,
  input  logic [MASTER_W-1:0] master,
  input  logic                cfg_ns,
  output logic                viol_valid,
  output logic [ADDR_W-1:0]   viol_addr,
  output logic                viol_nonsec,
  output logic [MASTER_W-1:0] viol_master,
  output logic                viol_cfg
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) viol_valid <= 1'b0;
    else        viol_valid <= hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_addr   <= '0;
      viol_nonsec <= 1'b0;
      viol_master <= '0;
      viol_cfg    <= 1'b0;
    end else if (hit) begin
      viol_addr   <= addr;
      viol_nonsec <= nonsec;
      viol_master <= master;
      viol_cfg    <= cfg_ns;
    end
  end

endmodule

// File: rtl/ahb_blk_sec_filter.sv
module ahb_blk_sec_filter
  import ahb_sf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int MASTER_W   = 4,
  parameter int NUM_BLOCKS = 64,
  parameter int SIZE_W     = 4,
  parameter int RST_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [SIZE_W-1:0]     size_code,
  input  logic [NUM_BLOCKS-1:0] blk_table,
  input  logic                  err_mode,
  input  logic                  gate_req,
  output logic                  gate_ack,
  input  logic [ADDR_W-1:0]     s_haddr,
  input  logic [1:0]            s_htrans,
  input  logic                  s_hwrite,
  input  logic [2:0]            s_hsize,
  input  logic                  s_hnonsec,
  input  logic [MASTER_W-1:0]   s_hmaster,
  input  logic [DATA_W-1:0]     s_hwdata,
  output logic [DATA_W-1:0]     s_hrdata,
  output logic                  s_hreadyout,
  output logic                  s_hresp,
  output logic [ADDR_W-1:0]     m_haddr,
  output logic [1:0]            m_htrans,
  output logic                  m_hwrite,
  output logic [2:0]            m_hsize,
  output logic                  m_hnonsec,
  output logic [DATA_W-1:0]     m_hwdata,
  output logic                  m_hready,
  input  logic [DATA_W-1:0]     m_hrdata,
  input  logic                  m_hreadyout,
  input  logic                  m_hresp,
  output logic                  viol_valid,
  output logic [ADDR_W-1:0]     viol_addr,
  output logic                  viol_nonsec,
  output logic [MASTER_W-1:0]   viol_master,
  output logic                  viol_cfg
);

  // reset: asserted at once, released through a synchroniser
  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[RST_STAGES-1];

  logic cfg_ns;
  logic xfer_active;
  logic violation;
  logic accept;
  logic forward;
  logic viol_hit;

  sf_lookup #(
    .ADDR_W     (ADDR_W),
    .NUM_BLOCKS (NUM_BLOCKS),
    .SIZE_W     (SIZE_W)
  ) u_lookup (
    .addr      (s_haddr),
    .size_code (size_code),
    .blk_table (blk_table),
    .cfg_ns    (cfg_ns)
  );

  assign xfer_active = s_htrans[1];
  assign violation   = xfer_active && (s_hnonsec != cfg_ns);

  sf_dphase #(
    .DATA_W (DATA_W)
  ) u_dphase (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .gate_req    (gate_req),
    .err_mode    (err_mode),
    .xfer_active (xfer_active),
    .violation   (violation),
    .m_hrdata    (m_hrdata),
    .m_hreadyout (m_hreadyout),
    .m_hresp     (m_hresp),
    .s_hrdata    (s_hrdata),
    .s_hreadyout (s_hreadyout),
    .s_hresp     (s_hresp),
    .m_hready    (m_hready),
    .accept      (accept),
    .gate_ack    (gate_ack)
  );

  assign forward  = accept && xfer_active && !violation;
  assign viol_hit = accept && violation;

  assign m_haddr   = s_haddr;
  assign m_htrans  = forward ? s_htrans : HTRANS_IDLE;
  assign m_hwrite  = s_hwrite;
  assign m_hsize   = s_hsize;
  assign m_hnonsec = s_hnonsec;
  assign m_hwdata  = s_hwdata;

  sf_viol_report #(
    .ADDR_W   (ADDR_W),
    .MASTER_W (MASTER_W)
  ) u_report (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .hit         (viol_hit),
    .addr        (s_haddr),
    .nonsec      (s_hnonsec),
    .master      (s_hmaster),
    .cfg_ns      (cfg_ns),
    .viol_valid  (viol_valid),
    .viol_addr   (viol_addr),
    .viol_nonsec (viol_nonsec),
    .viol_master (viol_master),
    .viol_cfg    (viol_cfg)
  );

endmodule

// File: rtl/ahb_blk_sec_filter_chk.sv
module ahb_blk_sec_filter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] s_htrans,
  input logic       s_hreadyout,
  input logic       s_hresp,
  input logic [1:0] m_htrans,
  input logic       gate_req,
  input logic       gate_ack,
  input logic       viol_valid
);

  AST_ERR_TWO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_hreadyout && s_hresp) |=> s_hresp); // R5

  AST_NO_LEAK: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid |-> ($past(m_htrans[1]) == 1'b0)); // R3

  AST_GATE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    gate_req |-> (m_htrans[1] == 1'b0)); // R8

  AST_ACK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    gate_ack |-> !s_hreadyout); // R9

  AST_IDLE_OKAY: assert property (@(posedge clk) disable iff (!rst_n)
    (s_hreadyout && !s_htrans[1]) |=> !s_hresp); // R6

  AST_VIOL_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid |-> $past(s_htrans[1] && s_hreadyout)); // R7

endmodule

bind ahb_blk_sec_filter ahb_blk_sec_filter_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .s_htrans    (s_htrans),
  .s_hreadyout (s_hreadyout),
  .s_hresp     (s_hresp),
  .m_htrans    (m_htrans),
  .gate_req    (gate_req),
  .gate_ack    (gate_ack),
  .viol_valid  (viol_valid)
);

// File: tb/tb_ahb_blk_sec_filter.sv
`timescale 1ns/1ps
module tb_ahb_blk_sec_filter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  size_code = 4'd0;
  logic [63:0] blk_table = 64'h0000_0000_F0F0_33A9;
  logic        err_mode = 1'b0;
  logic        gate_req = 1'b0;
  logic        gate_ack;
  logic [31:0] s_haddr = '0;
  logic [1:0]  s_htrans = 2'b00;
  logic        s_hwrite = 1'b0;
  logic [2:0]  s_hsize = 3'd2;
  logic        s_hnonsec = 1'b0;
  logic [3:0]  s_hmaster = 4'd0;
  logic [31:0] s_hwdata = '0;
  logic [31:0] s_hrdata;
  logic        s_hreadyout, s_hresp;
  logic [31:0] m_haddr;
  logic [1:0]  m_htrans;
  logic        m_hwrite, m_hnonsec, m_hready;
  logic [2:0]  m_hsize;
  logic [31:0] m_hwdata;
  logic [31:0] m_hrdata;
  logic        m_hreadyout;
  logic        m_hresp;
  logic        viol_valid, viol_nonsec, viol_cfg;
  logic [31:0] viol_addr;
  logic [3:0]  viol_master;

  always #2 clk = ~clk;

  ahb_blk_sec_filter dut (
    .clk(clk), .rst_n(rst_n), .size_code(size_code), .blk_table(blk_table),
    .err_mode(err_mode), .gate_req(gate_req), .gate_ack(gate_ack),
    .s_haddr(s_haddr), .s_htrans(s_htrans), .s_hwrite(s_hwrite), .s_hsize(s_hsize),
    .s_hnonsec(s_hnonsec), .s_hmaster(s_hmaster), .s_hwdata(s_hwdata),
    .s_hrdata(s_hrdata), .s_hreadyout(s_hreadyout), .s_hresp(s_hresp),
    .m_haddr(m_haddr), .m_htrans(m_htrans), .m_hwrite(m_hwrite), .m_hsize(m_hsize),
    .m_hnonsec(m_hnonsec), .m_hwdata(m_hwdata), .m_hready(m_hready),
    .m_hrdata(m_hrdata), .m_hreadyout(m_hreadyout), .m_hresp(m_hresp),
    .viol_valid(viol_valid), .viol_addr(viol_addr), .viol_nonsec(viol_nonsec),
    .viol_master(viol_master), .viol_cfg(viol_cfg)
  );

  // memory model
  logic [31:0] mem [256];
  logic [31:0] ref_mem [256];
  logic        mem_dp = 1'b0;
  logic [7:0]  mem_idx = '0;
  logic        mem_wr = 1'b0;
  int          wcnt = 0;
  int          mem_wait = 0;
  int          mem_hits = 0;

  assign m_hreadyout = !mem_dp || (wcnt == 0);
  assign m_hrdata    = mem[mem_idx];
  assign m_hresp     = 1'b0;

  always @(posedge clk) begin
    if (mem_dp && m_hreadyout) begin
      if (mem_wr) mem[mem_idx] <= m_hwdata;
      mem_dp <= 1'b0;
    end else if (mem_dp) begin
      wcnt <= wcnt - 1;
    end
    if (m_hready && m_htrans[1]) begin
      mem_dp   <= 1'b1;
      mem_idx  <= m_haddr[9:2];
      mem_wr   <= m_hwrite;
      wcnt     <= mem_wait;
      mem_hits <= mem_hits + 1;
    end
  end

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int exp_viols = 0;
  int seen_viols = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // scoreboard
  typedef struct {
    bit          err;
    bit          chk_data;
    logic [31:0] rdata;
    string       tag;
  } exp_t;
  exp_t exp_q[$];
  bit   dp_flag = 1'b0;
  logic prev_rdy = 1'b1;
  logic prev_resp = 1'b0;

  always @(negedge clk) begin
    if (viol_valid) seen_viols++;
    if (dp_flag && s_hreadyout) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2", "unexpected completion", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(s_hresp == e.err, e.tag, "response", {31'd0, s_hresp}, {31'd0, e.err});
        if (e.err)
          chk(!prev_rdy && prev_resp, "R5", "first error cycle ready/resp",
              {30'd0, prev_rdy, prev_resp}, 32'd1);
        if (e.chk_data)
          chk(s_hrdata == e.rdata, e.tag, "read data", s_hrdata, e.rdata);
      end
    end
    prev_rdy  = s_hreadyout;
    prev_resp = s_hresp;
  end

  function automatic logic exp_cfg(input logic [31:0] a);
    logic [31:0] blk;
    blk = a >> (size_code + 4'd5);  // R1
    return (blk < 32'd64) ? blk_table[blk[5:0]] : 1'b0;
  endfunction

  // driver: caller starts just after a rising edge
  task automatic xfer(input logic [31:0] a, input bit wr, input bit ns,
                      input logic [31:0] wd, input logic [1:0] tr, input string tag);
    logic cfg;
    bit   act, viol, r;
    int   hits0, waits;
    exp_t e;
    cfg   = exp_cfg(a);
    act   = tr[1];
    viol  = act && (ns != cfg);
    hits0 = mem_hits;
    s_haddr = a; s_hwrite = wr; s_hnonsec = ns; s_htrans = tr;
    s_hmaster = a[5:2];
    do begin
      @(negedge clk); r = s_hreadyout;
      @(posedge clk);
    end while (!r);
    e.err      = viol && err_mode;
    e.chk_data = !wr && act;
    e.rdata    = (act && !viol) ? ref_mem[a[9:2]] : 32'd0;
    e.tag      = tag;
    exp_q.push_back(e);
    if (viol) exp_viols++;
    #1;
    s_htrans = 2'b00; s_hwdata = wd; dp_flag = 1'b1;
    @(negedge clk);
    chk(viol_valid == viol, "R7", "violation pulse", {31'd0, viol_valid}, {31'd0, viol});
    if (viol) begin
      chk(viol_addr == a, "R7", "reported address", viol_addr, a);
      chk({viol_nonsec, viol_cfg, viol_master} == {ns, cfg, a[5:2]}, "R7",
          "reported attributes", {26'd0, viol_nonsec, viol_cfg, viol_master},
          {26'd0, ns, cfg, a[5:2]});
    end
    waits = 0;
    r = s_hreadyout;
    while (!r) begin
      @(posedge clk); @(negedge clk); r = s_hreadyout; waits++;
    end
    @(posedge clk); #1;
    dp_flag = 1'b0;
    if (!act) chk(waits == 0, "R6", "idle/busy wait states", waits, 0);
    else if (viol && !err_mode) chk(waits == 0, "R4", "silent block wait states", waits, 0);
    else if (viol) chk(waits == 1, "R5", "error wait states", waits, 1);
    chk(mem_hits - hits0 == ((act && !viol) ? 1 : 0), viol ? "R3" : "R2",
        "memory transfers", mem_hits - hits0, (act && !viol) ? 1 : 0);
    if (act && !viol && wr) ref_mem[a[9:2]] = wd;
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = '0; ref_mem[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(s_hreadyout && !s_hresp && !gate_ack && !viol_valid && (m_htrans == 2'b00),
        "R6", "reset state", {27'd0, s_hreadyout, s_hresp, gate_ack, viol_valid, m_htrans[1]},
        32'h10);
    @(posedge clk); #1;

    // R2: allowed accesses, non-secure block 0 and secure block 1 (32-byte blocks)
    xfer(32'h04, 1, 1, 32'hA5A5_0001, 2'b10, "R2");
    xfer(32'h24, 1, 0, 32'h5A5A_0002, 2'b10, "R2");
    xfer(32'h04, 0, 1, 0, 2'b10, "R2");
    xfer(32'h24, 0, 0, 0, 2'b11, "R2");

    // R4: silent blocking
    xfer(32'h24, 1, 1, 32'hDEAD_BEEF, 2'b10, "R4");
    xfer(32'h24, 0, 0, 0, 2'b10, "R4");
    xfer(32'h24, 0, 1, 0, 2'b10, "R4");
    xfer(32'h04, 0, 0, 0, 2'b10, "R2");

    // R2: memory wait states pass through
    mem_wait = 2;
    xfer(32'h04, 0, 1, 0, 2'b10, "R2");
    mem_wait = 0;

    // R5: error response
    err_mode = 1'b1;
    xfer(32'h28, 0, 1, 0, 2'b10, "R5");
    xfer(32'h08, 1, 0, 32'h1111_2222, 2'b10, "R5");
    err_mode = 1'b0;
    xfer(32'h08, 0, 1, 0, 2'b10, "R4");

    // R1: block size changes the lookup; out-of-range is secure
    xfer(32'h60, 1, 1, 32'h0000_0660, 2'b10, "R1");
    size_code = 4'd1;
    xfer(32'h60, 0, 1, 0, 2'b10, "R1");
    xfer(32'h60, 0, 0, 0, 2'b10, "R1");
    size_code = 4'd2;
    xfer(32'h60, 0, 1, 0, 2'b10, "R1");
    size_code = 4'd0;
    xfer(32'h800, 1, 0, 32'h0000_0800, 2'b10, "R1");
    xfer(32'h800, 0, 1, 0, 2'b10, "R1");

    // R6: idle and busy with violating attributes
    xfer(32'h24, 0, 1, 0, 2'b01, "R6");
    xfer(32'h24, 1, 1, 0, 2'b00, "R6");

    // R8/R9: gating with nothing outstanding
    gate_req = 1'b1;
    @(negedge clk);
    chk(gate_ack, "R9", "ack with port quiet", {31'd0, gate_ack}, 32'd1);
    @(posedge clk); #1;
    s_haddr = 32'h04; s_hnonsec = 1'b1; s_hwrite = 1'b0; s_htrans = 2'b10;
    begin
      int h0;
      h0 = mem_hits;
      repeat (3) begin
        @(negedge clk);
        chk(!s_hreadyout && (m_htrans == 2'b00), "R8", "stall while gated",
            {30'd0, s_hreadyout, m_htrans[1]}, 32'd0);
        @(posedge clk);
      end
      chk(mem_hits == h0, "R8", "no memory transfer while gated", mem_hits, h0);
    end
    #1 gate_req = 1'b0;
    xfer(32'h04, 0, 1, 0, 2'b10, "R8");

    // R9: gating arrives as the memory finishes a wait-stated read
    mem_wait = 2;
    fork
      xfer(32'h04, 0, 1, 0, 2'b10, "R9");
      begin
        repeat (3) @(posedge clk);
        #1 gate_req = 1'b1;
        @(negedge clk);
        chk(!gate_ack, "R9", "no ack while memory busy", {31'd0, gate_ack}, 32'd0);
        @(posedge clk); @(negedge clk);
        chk(gate_ack && !s_hreadyout, "R9", "ack after memory completes",
            {30'd0, gate_ack, s_hreadyout}, 32'd2);
        repeat (3) begin
          @(posedge clk); @(negedge clk);
          chk(!s_hreadyout, "R9", "response held while gated", {31'd0, s_hreadyout}, 32'd0);
        end
        @(posedge clk); #1 gate_req = 1'b0;
      end
    join
    mem_wait = 0;

    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(seen_viols == exp_viols, "R7", "one pulse per violation", seen_viols, exp_viols);
    chk(exp_q.size() == 0, "R2", "scoreboard drained", exp_q.size(), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule